// File: doc/BRIEF.md
# Embedded Operations Word Receive Filter

This block sits between a line deframer and a host register port. The deframer delivers the embedded-operations word of a subchannel twice per superframe, at the mid-point and at the end, so a new word arrives about every 6 ms. Each arrival comes with a one-cycle strobe. A 2-bit mode input sets the policy for when that word is copied into the host-visible receive register. The choices are: only after a run of identical words confirms it, whenever it differs from the value already held, or on every arrival. Every copy raises a one-cycle interrupt pulse when interrupts are enabled. Every copy also sets a level flag, which stays set until the host reads the register.

Nothing is copied unless superframe sync is present. Losing sync also discards any run of matching words in progress. In the other direction, the host writes a transmit word. The block stages that word and gives it to the framer at the next word boundary. A host write is dropped while automatic message processing is active. The receive register keeps updating in that case, so the host can still watch the traffic.

Top module: `eow_rx_filter`

## Requirements
- R1: After reset, held_word_o and tx_word_o are 0 and upd_irq_o and upd_flag_o are 0.
- R2: With mode_i = 2'b00 or 2'b10 (confirmation), held_word_o loads a word on the strobe that completes a run of three consecutive identical received words. Further identical words do not load it again.
- R3: In confirmation mode, a received word that differs from the previous one restarts the run at one. A strobe taken while sync_i is 0 clears the run to zero.
- R4: With mode_i = 2'b11, every received word loads held_word_o and counts as an update, even when the value is unchanged.
- R5: With mode_i = 2'b01, a received word loads held_word_o only if it differs from the value held.
- R6: No update happens while sync_i is 0. A strobe in that state leaves held_word_o, upd_irq_o and upd_flag_o unchanged.
- R7: An update loads held_word_o on the clock edge that samples rx_strobe_i. Over the following cycle it pulses upd_irq_o for exactly one cycle, but only if irq_en_i is 1. The load itself does not depend on irq_en_i.
- R8: upd_flag_o is set by every update and cleared by host_read_i. When both happen in the same cycle, set wins.
- R9: A host word written with host_wr_i appears on tx_word_o only after the next tx_strobe_i, on the edge that samples that strobe.
- R10: While auto_en_i is 1, host writes are ignored and tx_word_o keeps its value. Received words still update held_word_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sync_i | input | 1 | Superframe sync present |
| rx_strobe_i | input | 1 | One-cycle marker of a received word |
| rx_word_i | input | W | Received word, valid with the strobe |
| mode_i | input | 2 | Update policy: 00/10 confirm, 01 on change, 11 every word |
| irq_en_i | input | 1 | Interrupt enable |
| host_read_i | input | 1 | Host read of the receive register, clears the flag |
| host_wr_i | input | 1 | Host write of the transmit word |
| host_word_i | input | W | Transmit word from host |
| auto_en_i | input | 1 | Automatic processing active; blocks host writes |
| tx_strobe_i | input | 1 | Transmit word boundary from framer |
| tx_word_o | output | W | Word handed to the transmit framer |
| held_word_o | output | W | Host-visible receive register |
| upd_irq_o | output | 1 | One-cycle update interrupt |
| upd_flag_o | output | 1 | Update pending flag |

## Verification
The assertions assume that rx_strobe_i and tx_strobe_i are single-cycle pulses. They also assume that mode_i and irq_en_i are steady around a strobe, so the policy applied can be traced back to the cycle that sampled the strobe. The bench changes every input only on the falling edge. It sets mode, sync and enables before it raises a strobe, and it always lowers a strobe after one cycle. Mode and sync are changed only between strobes.

// File: rtl/eow_pkg.sv
package eow_pkg;
   typedef enum logic [1:0] {
      EOW_CONFIRM   = 2'b00,
      EOW_ON_CHANGE = 2'b01,
      EOW_CONFIRM_B = 2'b10,
      EOW_EVERY     = 2'b11
   } eow_mode_e;
endpackage

// File: rtl/eow_confirm.sv
module eow_confirm #(
   parameter int W         = 12,
   parameter int CONFIRM_N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sync_i,
   input  logic         strobe_i,
   input  logic [W-1:0] word_i,
   output logic         hit_o
);
   localparam int CW = $clog2(CONFIRM_N + 1);

   initial begin
      if (CONFIRM_N < 1) $error("CONFIRM_N must be at least 1");
   end

   generate
      if (CONFIRM_N == 1) begin : g_bypass
         assign hit_o = strobe_i && sync_i;
      end else begin : g_count
         logic [W-1:0]  prev_q;
         logic [CW-1:0] run_q, run_nx;
         logic          same;

         assign same = (word_i == prev_q);

         always_comb begin
            if (!same)                        run_nx = CW'(1);
            else if (run_q == CW'(CONFIRM_N)) run_nx = run_q;
            else                              run_nx = run_q + CW'(1);
         end

         assign hit_o = strobe_i && sync_i && (run_nx == CW'(CONFIRM_N))
                        && (run_q != CW'(CONFIRM_N));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               prev_q <= '0;
               run_q  <= '0;
            end else if (strobe_i) begin
               if (sync_i) begin
                  prev_q <= word_i;
                  run_q  <= run_nx;
               end else begin
                  run_q  <= '0;
               end
            end
         end

         // R3
         run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
            run_q <= CW'(CONFIRM_N));
         // R3
         run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (strobe_i && !sync_i) |=> (run_q == '0));
      end
   endgenerate
endmodule

// File: rtl/eow_rx_update.sv
module eow_rx_update
   import eow_pkg::*;
#(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sync_i,
   input  logic         strobe_i,
   input  logic [W-1:0] word_i,
   input  logic [1:0]   mode_i,
   input  logic         hit_i,
   input  logic         irq_en_i,
   input  logic         host_read_i,
   output logic [W-1:0] held_o,
   output logic         irq_o,
   output logic         flag_o
);
   logic      upd;
   eow_mode_e mode;

   assign mode = eow_mode_e'(mode_i);

   always_comb begin
      upd = 1'b0;
      if (strobe_i && sync_i) begin
         unique case (mode)
            EOW_EVERY:     upd = 1'b1;
            EOW_ON_CHANGE: upd = (word_i != held_o);
            default:       upd = hit_i;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_o <= '0;
         irq_o  <= 1'b0;
         flag_o <= 1'b0;
      end else begin
         irq_o <= upd && irq_en_i;
         if (upd) held_o <= word_i;
         if (upd)              flag_o <= 1'b1;
         else if (host_read_i) flag_o <= 1'b0;
      end
   end

   // R6
   held_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(held_o) |-> $past(strobe_i && sync_i));
   // R7
   irq_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> $past(irq_en_i));
   // R8
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> flag_o);
   // R4
   every_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && sync_i && mode_i == 2'b11 && irq_en_i) |=> irq_o);
   // R5
   on_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_i && sync_i && mode_i == 2'b01 && word_i != held_o)
      |=> (held_o == $past(word_i)));
endmodule

// File: rtl/eow_tx_stage.sv
module eow_tx_stage #(
   parameter int W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         host_wr_i,
   input  logic [W-1:0] host_word_i,
   input  logic         auto_en_i,
   input  logic         tx_strobe_i,
   output logic [W-1:0] tx_word_o
);
   logic [W-1:0] pend_q;
   logic         pend_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q    <= '0;
         pend_v    <= 1'b0;
         tx_word_o <= '0;
      end else begin
         if (tx_strobe_i && pend_v) tx_word_o <= pend_q;
         if (host_wr_i && !auto_en_i) begin
            pend_q <= host_word_i;
            pend_v <= 1'b1;
         end else if (tx_strobe_i) begin
            pend_v <= 1'b0;
         end
      end
   end

   // R9
   tx_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_word_o) |-> $past(tx_strobe_i));
endmodule

// File: rtl/eow_rx_filter.sv
module eow_rx_filter #(
   parameter int W         = 12,
   parameter int CONFIRM_N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sync_i,
   input  logic         rx_strobe_i,
   input  logic [W-1:0] rx_word_i,
   input  logic [1:0]   mode_i,
   input  logic         irq_en_i,
   input  logic         host_read_i,
   input  logic         host_wr_i,
   input  logic [W-1:0] host_word_i,
   input  logic         auto_en_i,
   input  logic         tx_strobe_i,
   output logic [W-1:0] tx_word_o,
   output logic [W-1:0] held_word_o,
   output logic         upd_irq_o,
   output logic         upd_flag_o
);
   initial begin
      if (W < 1) $error("W must be at least 1");
   end

   logic hit;

   eow_confirm #(.W(W), .CONFIRM_N(CONFIRM_N)) confirm_i (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .strobe_i(rx_strobe_i),
      .word_i(rx_word_i), .hit_o(hit));

   eow_rx_update #(.W(W)) update_i (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .strobe_i(rx_strobe_i),
      .word_i(rx_word_i), .mode_i(mode_i), .hit_i(hit), .irq_en_i(irq_en_i),
      .host_read_i(host_read_i), .held_o(held_word_o), .irq_o(upd_irq_o),
      .flag_o(upd_flag_o));

   eow_tx_stage #(.W(W)) tx_i (
      .clk(clk), .rst_n(rst_n), .host_wr_i(host_wr_i), .host_word_i(host_word_i),
      .auto_en_i(auto_en_i), .tx_strobe_i(tx_strobe_i), .tx_word_o(tx_word_o));

   // R10
   auto_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_en_i && !tx_strobe_i) |=> $stable(tx_word_o));
endmodule

// File: tb/eow_rx_filter_tb.sv
`timescale 1ns/1ps
module eow_rx_filter_tb_top;
   localparam int W = 12;

   logic clk = 1'b0, rst_n = 1'b0;
   logic sync_i = 0, rx_strobe_i = 0, irq_en_i = 0, host_read_i = 0;
   logic host_wr_i = 0, auto_en_i = 0, tx_strobe_i = 0;
   logic [W-1:0] rx_word_i = '0, host_word_i = '0;
   logic [1:0] mode_i = 2'b00;
   logic [W-1:0] tx_word_o, held_word_o;
   logic upd_irq_o, upd_flag_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   int brun;
   logic [W-1:0] bprev, bheld;

   always #2.5 clk = ~clk;

   eow_rx_filter #(.W(W), .CONFIRM_N(3)) dut_i (.*);

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; sync_i = 0; rx_strobe_i = 0; host_read_i = 0;
      host_wr_i = 0; auto_en_i = 0; tx_strobe_i = 0; irq_en_i = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      brun = 0; bprev = '0; bheld = '0;
   endtask

   // Drive one received word and check the register and interrupt.
   task automatic rx(input logic [W-1:0] w, input string req);
      bit upd;
      int oldrun;
      @(negedge clk);
      rx_word_i = w; rx_strobe_i = 1;
      upd = 0;
      if (sync_i) begin
         oldrun = brun;
         if (w == bprev) brun = (brun < 3) ? brun + 1 : 3;
         else brun = 1;
         bprev = w;
         case (mode_i)
            2'b11: upd = 1;
            2'b01: upd = (w != bheld);
            default: upd = (brun == 3 && oldrun == 2);
         endcase
         if (upd) bheld = w;
      end else brun = 0;
      @(negedge clk);
      rx_strobe_i = 0;
      check(req, held_word_o, bheld);
      check(req, upd_irq_o, upd && irq_en_i);
      if (upd) check(req, upd_flag_o, 1);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      check("R1", held_word_o, 0);
      check("R1", tx_word_o, 0);
      check("R1", upd_irq_o, 0);
      check("R1", upd_flag_o, 0);

      // Sweep over modes and run lengths: R2 R4 R5
      for (int m = 0; m < 4; m++) begin
         for (int k = 1; k <= 4; k++) begin
            do_reset();
            sync_i = 1; irq_en_i = 1; mode_i = 2'(m);
            for (int i = 0; i < 12; i++) begin
               logic [W-1:0] w;
               w = W'(((i / k) * 12'h155 + m + 1) & 12'hFFF);
               rx(w, m == 3 ? "R4" : (m == 1 ? "R5" : "R2"));
            end
         end
      end

      // R3 run restart and clearing on sync loss
      do_reset();
      sync_i = 1; irq_en_i = 1; mode_i = 2'b00;
      rx(12'hA5A, "R3"); rx(12'hA5A, "R3"); rx(12'h111, "R3");
      rx(12'hA5A, "R3"); rx(12'hA5A, "R3");
      check("R3", held_word_o, 0);
      rx(12'hA5A, "R3");
      check("R3", held_word_o, 12'hA5A);
      rx(12'h777, "R3"); rx(12'h777, "R3");
      sync_i = 0;
      rx(12'h777, "R6");
      sync_i = 1;
      rx(12'h777, "R3"); rx(12'h777, "R3");
      check("R3", held_word_o, 12'hA5A);
      rx(12'h777, "R3");
      check("R3", held_word_o, 12'h777);

      // R6 no update without sync, any mode
      do_reset();
      irq_en_i = 1; mode_i = 2'b11; sync_i = 0;
      rx(12'h3C3, "R6");
      check("R6", held_word_o, 0);
      check("R6", upd_flag_o, 0);

      // R7 irq disabled: register still loads
      sync_i = 1; irq_en_i = 0;
      rx(12'h0F0, "R7");
      check("R7", upd_irq_o, 0);
      check("R7", upd_flag_o, 1);
      // R7 single-cycle pulse
      irq_en_i = 1;
      rx(12'h0F0, "R7");
      @(negedge clk);
      check("R7", upd_irq_o, 0);

      // R8 flag clear and set-wins
      host_read_i = 1; @(negedge clk); host_read_i = 0;
      check("R8", upd_flag_o, 0);
      host_read_i = 1;
      rx(12'h0F1, "R8");
      host_read_i = 0;
      check("R8", upd_flag_o, 1);

      // R9 staging to boundary
      @(negedge clk); host_word_i = 12'hABC; host_wr_i = 1;
      @(negedge clk); host_wr_i = 0;
      repeat (2) @(negedge clk);
      check("R9", tx_word_o, 0);
      tx_strobe_i = 1; @(negedge clk); tx_strobe_i = 0;
      check("R9", tx_word_o, 12'hABC);

      // R10 write ignored under automatic processing, rx continues
      auto_en_i = 1;
      @(negedge clk); host_word_i = 12'h123; host_wr_i = 1;
      @(negedge clk); host_wr_i = 0;
      tx_strobe_i = 1; @(negedge clk); tx_strobe_i = 0;
      check("R10", tx_word_o, 12'hABC);
      rx(12'h456, "R10");
      check("R10", held_word_o, 12'h456);

      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end
endmodule